// File: doc/BRIEF.md
# Two-Wire Controller Register Bank

This block is the control and status register bank of a two-wire serial bus controller. It sits on a simple request/acknowledge peripheral bus and holds the controller's configuration: clock divider, general control, slave-side control and address, master-side control and address, interrupt mask and FIFO control. It also gathers status from the serial engine and offers one-entry transmit and receive holding registers that connect to that engine. The serial engine itself is not part of the block. It appears only as set pulses for status flags, live busy and direction levels, captured status words and a receive-data load strobe.

Each 16-bit register sits on a 4-byte stride. Each register has its own access rule: plain read/write, read-only, write-one-to-clear on all bits, write-one-to-clear on a subset of bits, or a write-only port that reads back zero. Every access is checked for width and for address. A width error is reported even when the address is also unmapped.

A two-state bus controller paces the accesses. In `ST_IDLE` a raised `req` is accepted (transition ACCEPT): any write takes effect at that clock edge, and the read data is captured from the registers as they stood before the edge. The controller then moves to `ST_RESP`, where `ack` is high for exactly one cycle with `rdata` and `err_kind` valid. From there it always returns to `ST_IDLE` (transition RELEASE). The requester lowers `req` once it sees `ack`.

Top module: `twc_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears every register, the transmit and receive holding registers and all captured status to zero. After reset `ack`, `tx_load` and `irq` are low.
- R2: When `req` is high in `ST_IDLE`, `ack` rises on the next clock edge and stays high for exactly one cycle. `rdata` and `err_kind` are valid while `ack` is high and are zero otherwise.
- R3: An access with `size` other than 1 (encoding: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved) returns `err_kind` = 1 (width error) and `rdata` = 0, and changes nothing. This holds at unmapped addresses too, so a width error takes priority over an address error.
- R4: A 16-bit access to any byte address other than 0x00, 0x04, …, 0x2C and 0x80, 0x84, 0x88, 0x8C returns `err_kind` = 2 (unmapped) with `rdata` = 0, and changes nothing. A successful access returns `err_kind` = 0.
- R5: Clock divider (0x00), control (0x04), slave control (0x08), slave address (0x10), master control (0x14), master address (0x1C), interrupt mask (0x24) and FIFO control (0x28) are read/write. Each drives its `cfg_*` output, except the interrupt mask, which only gates `irq`. A write returns `rdata` = 0.
- R6: Interrupt status (0x20) ORs in `int_set` on every cycle. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set pulse in the same cycle as a clearing write leaves the bit set.
- R7: Master status (0x18) holds error flags at bit 2 (lost arbitration), bit 3 (address NAK), bit 4 (data NAK), bit 5 (buffer read error) and bit 6 (buffer write error). These are set by `mst_err_set[0..4]` in that order, cleared by writing 1, and a set pulse wins over a same-cycle clear. Bits 0 and 1 show `eng_busy` and `eng_dir` one cycle late and ignore writes. Bits 15..7 read zero.
- R8: Slave status (0x0C) and FIFO status (0x2C) hold `slv_stat_in` and `fifo_stat_in` captured on every cycle. Writes to them and to the receive ports are ignored and return `err_kind` = 0.
- R9: A write to 0x80 stores `{8'h00, wdata[7:0]}` into the transmit holding register, and a write to 0x84 stores all 16 bits. `tx_data` shows the stored value and `tx_load` pulses high in the `ack` cycle of that write. Reads of 0x80 and 0x84 return zero.
- R10: `rx_load` loads `rx_data` into the receive holding register. Reads of 0x88 and 0x8C both return it.
- R11: `irq` is high exactly when the interrupt status AND the interrupt mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `ack` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address within the bank |
| size | input | 2 | Access width code (1 = 16-bit) |
| wdata | input | 16 | Write data |
| ack | output | 1 | Response strobe, one cycle |
| rdata | output | 16 | Read data, valid with `ack` |
| err_kind | output | 2 | 0 ok, 1 width error, 2 unmapped |
| int_set | input | 16 | Interrupt status set pulses |
| mst_err_set | input | 5 | Master error flag set pulses |
| eng_busy | input | 1 | Engine busy level |
| eng_dir | input | 1 | Engine transfer direction level |
| slv_stat_in | input | 16 | Slave status word from engine |
| fifo_stat_in | input | 16 | FIFO status word from engine |
| rx_load | input | 1 | Receive holding register load strobe |
| rx_data | input | 16 | Received data |
| tx_data | output | 16 | Transmit holding register |
| tx_load | output | 1 | Pulse when transmit register is written |
| irq | output | 1 | Interrupt request |
| cfg_clkdiv | output | 16 | Clock divider register |
| cfg_ctrl | output | 16 | Control register |
| cfg_slv_ctl | output | 16 | Slave control register |
| cfg_slv_addr | output | 16 | Slave address register |
| cfg_mst_ctl | output | 16 | Master control register |
| cfg_mst_addr | output | 16 | Master address register |
| cfg_fifo_ctl | output | 16 | FIFO control register |

## Verification
The hardest case to produce from the ports is an engine set pulse that lands in the very clock edge where a write-one-to-clear to the same flag is accepted. This applies to both interrupt status and master status. The stimulus task drives the set pulse on the same falling edge that raises `req` while the controller is idle, so both meet at the accepting edge. Directed passes combine this with clear masks that overlap, cover and miss the pulsed bits, and a randomized phase repeats it with mixed widths, unmapped offsets and receive loads. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int DW       = 16;
    localparam int AW       = 8;
    localparam int NCTL     = 12;
    localparam int NDATA    = 4;
    localparam int NREG     = NCTL + NDATA;
    localparam int STRIDE   = 4;
    localparam int DBASE    = 128;
    localparam int IXW      = $clog2(NREG);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_WIDTH    = 2'd1,
        ERR_UNMAPPED = 2'd2
    } err_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam int IX_CLKDIV    = 0;
    localparam int IX_CTRL      = 1;
    localparam int IX_SLV_CTL   = 2;
    localparam int IX_SLV_STAT  = 3;
    localparam int IX_SLV_ADDR  = 4;
    localparam int IX_MST_CTL   = 5;
    localparam int IX_MST_STAT  = 6;
    localparam int IX_MST_ADDR  = 7;
    localparam int IX_INT_STAT  = 8;
    localparam int IX_INT_MASK  = 9;
    localparam int IX_FIFO_CTL  = 10;
    localparam int IX_FIFO_STAT = 11;
    localparam int IX_TX8       = 12;
    localparam int IX_TX16      = 13;
    localparam int IX_RX8       = 14;
    localparam int IX_RX16      = 15;

    localparam int MST_ERR_LSB  = 2;
    localparam int MST_ERR_W    = 5;
    localparam int MST_LIVE_W   = 2;
endpackage

// File: rtl/twc_decode.sv
module twc_decode
    import twc_pkg::*;
#(
    parameter int A_W   = AW,
    parameter int N_CTL = NCTL,
    parameter int N_DAT = NDATA,
    parameter int D_OFF = DBASE,
    parameter int STR   = STRIDE,
    parameter int IX_W  = IXW
) (
    input  logic [A_W-1:0]  addr,
    input  logic [1:0]      size,
    output logic [1:0]      err_kind,
    output logic [IX_W-1:0] idx
);
    localparam int N_ALL = N_CTL + N_DAT;

    logic [N_ALL-1:0] match;
    logic             hit;

    generate
        for (genvar g = 0; g < N_ALL; g++) begin : g_match
            localparam int OFF = (g < N_CTL) ? g * STR : D_OFF + (g - N_CTL) * STR;
            assign match[g] = (addr == A_W'(OFF));
        end
    endgenerate

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < N_ALL; i++) begin
            if (match[i]) idx = IX_W'(i);
        end
    end

    always_comb begin
        if (size != 2'(SZ_HALF))  err_kind = 2'(ERR_WIDTH);
        else if (!hit)            err_kind = 2'(ERR_UNMAPPED);
        else                      err_kind = 2'(ERR_NONE);
    end
endmodule

// File: rtl/twc_w1c_reg.sv
module twc_w1c_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_en ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_eff) | set_bits;
    end
endmodule

// File: rtl/twc_bus_fsm.sv
module twc_bus_fsm
    import twc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic accept,
    output logic ack
);
    bus_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        ack    = 1'b0;
        unique case (st_q)
            ST_IDLE: accept = req;
            ST_RESP: ack    = 1'b1;
        endcase
    end
endmodule

// File: rtl/twc_regbank.sv
module twc_regbank
    import twc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [1:0]  size,
    input  logic [15:0] wdata,
    output logic        ack,
    output logic [15:0] rdata,
    output logic [1:0]  err_kind,
    input  logic [15:0] int_set,
    input  logic [4:0]  mst_err_set,
    input  logic        eng_busy,
    input  logic        eng_dir,
    input  logic [15:0] slv_stat_in,
    input  logic [15:0] fifo_stat_in,
    input  logic        rx_load,
    input  logic [15:0] rx_data,
    output logic [15:0] tx_data,
    output logic        tx_load,
    output logic        irq,
    output logic [15:0] cfg_clkdiv,
    output logic [15:0] cfg_ctrl,
    output logic [15:0] cfg_slv_ctl,
    output logic [15:0] cfg_slv_addr,
    output logic [15:0] cfg_mst_ctl,
    output logic [15:0] cfg_mst_addr,
    output logic [15:0] cfg_fifo_ctl
);
    localparam int NRW = 8;
    localparam int RW_IX [NRW] = '{IX_CLKDIV, IX_CTRL, IX_SLV_CTL, IX_SLV_ADDR,
                                   IX_MST_CTL, IX_MST_ADDR, IX_INT_MASK, IX_FIFO_CTL};
    localparam int P_CLKDIV   = 0;
    localparam int P_CTRL     = 1;
    localparam int P_SLV_CTL  = 2;
    localparam int P_SLV_ADDR = 3;
    localparam int P_MST_CTL  = 4;
    localparam int P_MST_ADDR = 5;
    localparam int P_INT_MASK = 6;
    localparam int P_FIFO_CTL = 7;
    localparam int MST_PAD    = DW - MST_ERR_W - MST_LIVE_W;
    localparam int BYTE_W     = DW / 2;

    logic            accept;
    logic [1:0]      err_d;
    logic [IXW-1:0]  idx;
    logic            wr_go;
    logic [DW-1:0]   rw_q [NRW];
    logic [DW-1:0]   int_stat_q;
    logic [DW-1:0]   int_mask_q;
    logic [MST_ERR_W-1:0]  mst_err_q;
    logic [MST_LIVE_W-1:0] mst_live_q;
    logic [DW-1:0]   mst_stat_q;
    logic [DW-1:0]   slv_stat_q;
    logic [DW-1:0]   fifo_stat_q;
    logic [DW-1:0]   rx_q;
    logic [DW-1:0]   tx_q;
    logic            tx_load_q;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   rdata_q;
    logic [1:0]      err_q;
    logic            int_clr_en;
    logic            mst_clr_en;
    logic            tx8_go;
    logic            tx16_go;

    twc_bus_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .accept (accept),
        .ack    (ack)
    );

    twc_decode u_dec (
        .addr     (addr),
        .size     (size),
        .err_kind (err_d),
        .idx      (idx)
    );

    always_comb begin
        wr_go      = accept && wr && (err_d == 2'(ERR_NONE));
        int_clr_en = wr_go && (idx == IXW'(IX_INT_STAT));
        mst_clr_en = wr_go && (idx == IXW'(IX_MST_STAT));
        tx8_go     = wr_go && (idx == IXW'(IX_TX8));
        tx16_go    = wr_go && (idx == IXW'(IX_TX16));
    end

    generate
        for (genvar g = 0; g < NRW; g++) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    rw_q[g] <= '0;
                else if (wr_go && (idx == IXW'(RW_IX[g])))
                    rw_q[g] <= wdata;
            end
        end
    endgenerate

    twc_w1c_reg #(.W(DW)) u_int_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (int_clr_en),
        .clr_bits (wdata),
        .set_bits (int_set),
        .q        (int_stat_q)
    );

    twc_w1c_reg #(.W(MST_ERR_W)) u_mst_err (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (mst_clr_en),
        .clr_bits (wdata[MST_ERR_LSB +: MST_ERR_W]),
        .set_bits (mst_err_set),
        .q        (mst_err_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mst_live_q  <= '0;
            slv_stat_q  <= '0;
            fifo_stat_q <= '0;
            rx_q        <= '0;
        end else begin
            mst_live_q  <= {eng_dir, eng_busy};
            slv_stat_q  <= slv_stat_in;
            fifo_stat_q <= fifo_stat_in;
            if (rx_load) rx_q <= rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            tx_load_q <= 1'b0;
        end else begin
            tx_load_q <= tx8_go || tx16_go;
            if (tx8_go)       tx_q <= {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
            else if (tx16_go) tx_q <= wdata;
        end
    end

    always_comb begin
        mst_stat_q = {{MST_PAD{1'b0}}, mst_err_q, mst_live_q};
        int_mask_q = rw_q[P_INT_MASK];
    end

    always_comb begin
        rd_mux = '0;
        case (idx)
            IXW'(IX_CLKDIV):    rd_mux = rw_q[P_CLKDIV];
            IXW'(IX_CTRL):      rd_mux = rw_q[P_CTRL];
            IXW'(IX_SLV_CTL):   rd_mux = rw_q[P_SLV_CTL];
            IXW'(IX_SLV_STAT):  rd_mux = slv_stat_q;
            IXW'(IX_SLV_ADDR):  rd_mux = rw_q[P_SLV_ADDR];
            IXW'(IX_MST_CTL):   rd_mux = rw_q[P_MST_CTL];
            IXW'(IX_MST_STAT):  rd_mux = mst_stat_q;
            IXW'(IX_MST_ADDR):  rd_mux = rw_q[P_MST_ADDR];
            IXW'(IX_INT_STAT):  rd_mux = int_stat_q;
            IXW'(IX_INT_MASK):  rd_mux = int_mask_q;
            IXW'(IX_FIFO_CTL):  rd_mux = rw_q[P_FIFO_CTL];
            IXW'(IX_FIFO_STAT): rd_mux = fifo_stat_q;
            IXW'(IX_RX8):       rd_mux = rx_q;
            IXW'(IX_RX16):      rd_mux = rx_q;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= '0;
        end else if (accept) begin
            err_q   <= err_d;
            rdata_q <= (!wr && (err_d == 2'(ERR_NONE))) ? rd_mux : '0;
        end else begin
            rdata_q <= '0;
            err_q   <= '0;
        end
    end

    always_comb begin
        rdata        = rdata_q;
        err_kind     = err_q;
        tx_data      = tx_q;
        tx_load      = tx_load_q;
        irq          = |(int_stat_q & int_mask_q);
        cfg_clkdiv   = rw_q[P_CLKDIV];
        cfg_ctrl     = rw_q[P_CTRL];
        cfg_slv_ctl  = rw_q[P_SLV_CTL];
        cfg_slv_addr = rw_q[P_SLV_ADDR];
        cfg_mst_ctl  = rw_q[P_MST_CTL];
        cfg_mst_addr = rw_q[P_MST_ADDR];
        cfg_fifo_ctl = rw_q[P_FIFO_CTL];
    end
endmodule

// File: rtl/twc_regbank_chk.sv
module twc_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        wr,
    input logic [7:0]  addr,
    input logic [1:0]  size,
    input logic        ack,
    input logic [15:0] rdata,
    input logic [1:0]  err_kind,
    input logic [15:0] int_set,
    input logic [4:0]  mst_err_set,
    input logic [15:0] int_stat,
    input logic [15:0] int_mask,
    input logic [15:0] mst_stat,
    input logic        irq,
    input logic [15:0] tx_data
);
    // R2: response lasts one cycle
    p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R2: an idle request is answered on the next edge
    p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> ack);

    // R3: errored responses carry no data
    p_err_no_data_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && (err_kind != 2'd0)) |-> (rdata == 16'h0000));

    // R3: a non-16-bit access is reported as a width error
    p_width_first_r3: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && (size != 2'd1)) |=> (err_kind == 2'd1));

    // R6: a set pulse always leaves its bit set
    p_int_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (|int_set) |=> ((int_stat & $past(int_set)) == $past(int_set)));

    // R7: master error set pulses survive a same-cycle clear
    p_mst_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|mst_err_set) |=> ((mst_stat[6:2] & $past(mst_err_set)) == $past(mst_err_set)));

    // R7: upper master status bits stay zero
    p_mst_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        mst_stat[15:7] == 9'h000);

    // R9: byte transmit port zeroes the upper byte
    p_tx8_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && wr && (addr == 8'h80) && (size == 2'd1)) |=> (tx_data[15:8] == 8'h00));

    // R11: no interrupt while the mask is clear
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (int_mask == 16'h0000) |-> !irq);

    // R11: no interrupt while no status bit is pending
    p_irq_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (int_stat == 16'h0000) |-> !irq);
endmodule

bind twc_regbank twc_regbank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .wr          (wr),
    .addr        (addr),
    .size        (size),
    .ack         (ack),
    .rdata       (rdata),
    .err_kind    (err_kind),
    .int_set     (int_set),
    .mst_err_set (mst_err_set),
    .int_stat    (int_stat_q),
    .int_mask    (int_mask_q),
    .mst_stat    (mst_stat_q),
    .irq         (irq),
    .tx_data     (tx_data)
);

// File: tb/tb_twc_regbank.sv
`timescale 1ns/1ps
module tb_twc_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = 2'd1;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [1:0]  err_kind;
    logic [15:0] int_set = '0;
    logic [4:0]  mst_err_set = '0;
    logic        eng_busy = 1'b0;
    logic        eng_dir = 1'b0;
    logic [15:0] slv_stat_in = '0;
    logic [15:0] fifo_stat_in = '0;
    logic        rx_load = 1'b0;
    logic [15:0] rx_data = '0;
    logic [15:0] tx_data;
    logic        tx_load;
    logic        irq;
    logic [15:0] cfg_clkdiv, cfg_ctrl, cfg_slv_ctl, cfg_slv_addr;
    logic [15:0] cfg_mst_ctl, cfg_mst_addr, cfg_fifo_ctl;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    twc_regbank dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .size(size),
        .wdata(wdata), .ack(ack), .rdata(rdata), .err_kind(err_kind),
        .int_set(int_set), .mst_err_set(mst_err_set), .eng_busy(eng_busy),
        .eng_dir(eng_dir), .slv_stat_in(slv_stat_in), .fifo_stat_in(fifo_stat_in),
        .rx_load(rx_load), .rx_data(rx_data), .tx_data(tx_data), .tx_load(tx_load),
        .irq(irq), .cfg_clkdiv(cfg_clkdiv), .cfg_ctrl(cfg_ctrl),
        .cfg_slv_ctl(cfg_slv_ctl), .cfg_slv_addr(cfg_slv_addr),
        .cfg_mst_ctl(cfg_mst_ctl), .cfg_mst_addr(cfg_mst_addr),
        .cfg_fifo_ctl(cfg_fifo_ctl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] m_rw [0:11];
    logic [15:0] m_int, m_sstat, m_fstat, m_rx, m_tx;
    logic [4:0]  m_merr;
    logic [1:0]  m_live;
    logic        m_pend, m_txl;
    logic [15:0] e_rd;
    logic [1:0]  e_err;
    string       e_tag;
    logic [15:0] clr_i;
    logic [4:0]  clr_m;
    int          ix;

    function automatic bit mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && ((a <= 8'h2C) || (a >= 8'h80 && a <= 8'h8C));
    endfunction

    function automatic int to_ix(input logic [7:0] a);
        return (a < 8'h80) ? int'(a) / 4 : 12 + (int'(a) - 128) / 4;
    endfunction

    function automatic logic [15:0] m_read(input int i);
        case (i)
            3:  return m_sstat;
            6:  return {9'h000, m_merr, m_live};
            8:  return m_int;
            11: return m_fstat;
            12, 13: return 16'h0000;
            14, 15: return m_rx;
            default: return m_rw[i];
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            8:  return "R6 int_stat";
            6:  return "R7 mst_stat";
            3, 11, 14, 15: return (i >= 14) ? "R10 rx" : "R8 ro";
            12, 13: return "R9 tx";
            default: return "R5 rw";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 12; k++) m_rw[k] = '0;
            m_int = '0; m_sstat = '0; m_fstat = '0; m_rx = '0; m_tx = '0;
            m_merr = '0; m_live = '0; m_pend = 1'b0; m_txl = 1'b0;
            e_rd = '0; e_err = '0; e_tag = "R1";
        end else begin
            clr_i = '0;
            clr_m = '0;
            m_txl = 1'b0;
            if (!m_pend && req) begin
                m_pend = 1'b1;
                if (size != 2'd1) begin
                    e_err = 2'd1; e_rd = '0; e_tag = "R3 width";
                end else if (!mapped(addr)) begin
                    e_err = 2'd2; e_rd = '0; e_tag = "R4 unmapped";
                end else begin
                    ix = to_ix(addr);
                    e_err = 2'd0;
                    e_tag = tag_of(ix);
                    e_rd = wr ? 16'h0000 : m_read(ix);
                    if (wr) begin
                        case (ix)
                            0, 1, 2, 4, 5, 7, 9, 10: m_rw[ix] = wdata;
                            8:  clr_i = wdata;
                            6:  clr_m = wdata[6:2];
                            12: begin m_tx = {8'h00, wdata[7:0]}; m_txl = 1'b1; end
                            13: begin m_tx = wdata; m_txl = 1'b1; end
                            default: ;
                        endcase
                    end
                end
            end else begin
                m_pend = 1'b0;
            end
            m_int   = (m_int & ~clr_i) | int_set;
            m_merr  = (m_merr & ~clr_m) | mst_err_set;
            m_live  = {eng_dir, eng_busy};
            m_sstat = slv_stat_in;
            m_fstat = fifo_stat_in;
            if (rx_load) m_rx = rx_data;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 ack", ack, m_pend);
            if (m_pend) begin
                chk({e_tag, " rdata"}, rdata, e_rd);
                chk({e_tag, " err_kind"}, err_kind, e_err);
            end else begin
                chk("R2 idle rdata", rdata, 16'h0000);
            end
            chk("R11 irq", irq, |(m_int & m_rw[9]));
            chk("R9 tx_data", tx_data, m_tx);
            chk("R9 tx_load", tx_load, m_txl);
            chk("R5 cfg_clkdiv", cfg_clkdiv, m_rw[0]);
            chk("R5 cfg_ctrl", cfg_ctrl, m_rw[1]);
            chk("R5 cfg_slv_ctl", cfg_slv_ctl, m_rw[2]);
            chk("R5 cfg_slv_addr", cfg_slv_addr, m_rw[4]);
            chk("R5 cfg_mst_ctl", cfg_mst_ctl, m_rw[5]);
            chk("R5 cfg_mst_addr", cfg_mst_addr, m_rw[7]);
            chk("R5 cfg_fifo_ctl", cfg_fifo_ctl, m_rw[10]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit w, input logic [7:0] a, input logic [1:0] s,
                          input logic [15:0] d, input logic [15:0] iset = '0,
                          input logic [4:0] mset = '0);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; size = s; wdata = d;
        int_set = iset; mst_err_set = mset;
        @(negedge clk);
        int_set = '0; mst_err_set = '0;
        while (!ack) @(negedge clk);
        req = 1'b0;
    endtask

    task automatic rx_push(input logic [15:0] d);
        @(negedge clk);
        rx_load = 1'b1; rx_data = d;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 ack", ack, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 tx_load", tx_load, 1'b0);
        chk("R1 tx_data", tx_data, 16'h0000);
        for (int a = 0; a <= 8'h2C; a += 4) access(1'b0, 8'(a), 2'd1, '0);

        // R5: read/write registers
        for (int a = 0; a <= 8'h2C; a += 4) access(1'b1, 8'(a), 2'd1, 16'h1111 * 16'(a / 4 + 1));
        for (int a = 0; a <= 8'h2C; a += 4) access(1'b0, 8'(a), 2'd1, '0);

        // R8: read-only status capture and ignored writes
        slv_stat_in = 16'h5A5A; fifo_stat_in = 16'hC3C3;
        access(1'b1, 8'h0C, 2'd1, 16'hFFFF);
        access(1'b1, 8'h2C, 2'd1, 16'h0000);
        access(1'b0, 8'h0C, 2'd1, '0);
        access(1'b0, 8'h2C, 2'd1, '0);

        // R6 / R11: interrupt status set, partial clear, set-wins
        access(1'b1, 8'h24, 2'd0, 16'h0000);
        access(1'b1, 8'h24, 2'd1, 16'h00F0);
        access(1'b0, 8'h20, 2'd1, '0, 16'h0033);
        access(1'b1, 8'h20, 2'd1, 16'h0001);
        access(1'b0, 8'h20, 2'd1, '0);
        access(1'b1, 8'h20, 2'd1, 16'h0030, 16'h0010);
        access(1'b0, 8'h20, 2'd1, '0);
        access(1'b1, 8'h20, 2'd1, 16'hFFFF);
        access(1'b0, 8'h20, 2'd1, '0);

        // R7: master status
        eng_busy = 1'b1; eng_dir = 1'b1;
        access(1'b0, 8'h18, 2'd1, '0, '0, 5'b10101);
        access(1'b1, 8'h18, 2'd1, 16'hFFFF, '0, 5'b00100);
        access(1'b0, 8'h18, 2'd1, '0);
        eng_busy = 1'b0;
        access(1'b1, 8'h18, 2'd1, 16'h0010, '0, 5'b11011);
        access(1'b0, 8'h18, 2'd1, '0);

        // R9: transmit ports
        access(1'b1, 8'h80, 2'd1, 16'hABCD);
        access(1'b0, 8'h80, 2'd1, '0);
        access(1'b1, 8'h84, 2'd1, 16'hBEEF);
        access(1'b0, 8'h84, 2'd1, '0);

        // R10: receive ports
        rx_push(16'h1234);
        access(1'b0, 8'h88, 2'd1, '0);
        access(1'b1, 8'h8C, 2'd1, 16'h0000);
        access(1'b0, 8'h8C, 2'd1, '0);

        // R3 / R4: width priority and unmapped
        access(1'b1, 8'h00, 2'd0, 16'h7777);
        access(1'b1, 8'h84, 2'd2, 16'h7777);
        access(1'b0, 8'h40, 2'd3, '0);
        access(1'b1, 8'h30, 2'd1, 16'h7777);
        access(1'b0, 8'h90, 2'd1, '0);
        access(1'b1, 8'h01, 2'd1, 16'h7777);
        access(1'b0, 8'h7C, 2'd1, '0);
        access(1'b0, 8'h00, 2'd1, '0);
        access(1'b0, 8'h84, 2'd1, '0);

        // mixed random phase
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            logic [1:0] s;
            a = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 35) * 4);
            s = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd1;
            eng_busy = 1'($urandom); eng_dir = 1'($urandom);
            slv_stat_in = 16'($urandom); fifo_stat_in = 16'($urandom);
            if ($urandom_range(0, 4) == 0) rx_push(16'($urandom));
            access(1'($urandom), a, s, 16'($urandom),
                   ($urandom_range(0, 2) == 0) ? 16'($urandom) : 16'h0000,
                   ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'h00);
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule